// File: doc/BRIEF.md
# Timer Channel Compare Output Generator

This block computes the reference level of a single timer compare channel. The counter value, the counting direction and a tick strobe come from an external counter. The block compares the counter with a per-channel compare value and, under a 3-bit mode field, does one of three things. It can act on a compare match by holding, setting, clearing or toggling the level. It can force a fixed level. It can produce a pulse-width waveform in one of two polarities.

An external clear input, gated by its own enable, pulls the reference low. A small state machine then keeps it low until the next update-event pulse. The machine has two states, `ST_RUN` and `ST_CLEARED`, and four transitions:

- `ARM` takes `ST_RUN` to `ST_CLEARED` when the clear is seen.
- `RELEASE` takes `ST_CLEARED` back to `ST_RUN` on an update event with no clear in the same cycle.
- `STAY_RUN` and `STAY_CLEARED` keep the current state.

The reference level sits in one register. Any change of mode, compare value or counter shows on `ref_out` after the next rising clock edge. The active level is 1 and the inactive level is 0. Polarity, dead time and pin control belong to other blocks.

Top module: `chan_ref_gen`

## Requirements
- R1: With mode 0 and no clear in force, `ref_out` keeps its value on every edge, whether or not the counter matches.
- R2: Mode 1 sets `ref_out` to 1, and mode 2 sets it to 0, on an edge where `cnt_tick`=1 and `cnt_val`==`cmp_val`. On any other edge in these modes the level is unchanged.
- R3: Mode 3 inverts `ref_out` on each edge where `cnt_tick`=1 and `cnt_val`==`cmp_val`, and leaves it unchanged otherwise.
- R4: Mode 4 drives `ref_out` to 0 and mode 5 drives it to 1 on every edge, whatever the compare result and the tick.
- R5: Mode 6 is pulse-width mode A, evaluated on every edge. With `cnt_down`=0 (up), the next level is 1 when `cnt_val` < `cmp_val` and 0 otherwise. With `cnt_down`=1 (down), the next level is 0 when `cnt_val` > `cmp_val` and 1 otherwise.
- R6: Mode 7 is pulse-width mode B and gives the exact inverse of the R5 level for the same inputs.
- R7: An edge with `xclr_in`=1 and `xclr_en`=1 makes `ref_out` 0 after that edge and arms the clear state. `xclr_in`=1 with `xclr_en`=0 has no effect.
- R8: Once armed, `ref_out` stays 0 on every edge until an edge with `upd_evt`=1 and no new clear. At that edge the clear state is released and `ref_out` takes the value its mode gives, starting from 0. A clear and an update in the same cycle keep the clear state armed.
- R9: Reset (`rst_n`=0, asynchronous) gives `ref_out`=0 and the run state. A change of `mode` shows on `ref_out` only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Current counter value |
| cnt_down | input | 1 | Counting direction, 1 = down |
| cnt_tick | input | 1 | Counter advanced this cycle; qualifies match events |
| cmp_val | input | CNT_W | Channel compare value |
| mode | input | 3 | Output mode selection (0..7) |
| xclr_in | input | 1 | External clear request |
| xclr_en | input | 1 | Enable for the external clear |
| upd_evt | input | 1 | Update-event pulse |
| ref_out | output | 1 | Channel reference level |

## Verification
Each result of this block, whether a match action, a forced level, a pulse-width level, a clear or a release, is due exactly one rising edge after the inputs that cause it. The bench changes inputs 1 ns after a rising edge and reads `ref_out` 1 ns after the following rising edge, so it reads each result in the cycle it becomes valid. For the mode-change case it also reads `ref_out` just before that edge, to show that the old level is still present. Clear and release sequences are checked edge by edge, including the edge where a clear and an update arrive together.

// File: rtl/chan_ref_pkg.sv
package chan_ref_pkg;

    typedef enum logic [2:0] {
        CM_HOLD     = 3'd0,
        CM_SET      = 3'd1,
        CM_CLR      = 3'd2,
        CM_TOGGLE   = 3'd3,
        CM_FORCE_LO = 3'd4,
        CM_FORCE_HI = 3'd5,
        CM_PWM_A    = 3'd6,
        CM_PWM_B    = 3'd7
    } cmp_mode_e;

    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_CLEARED = 1'b1
    } clr_state_e;

    localparam logic LVL_ACTIVE   = 1'b1;
    localparam logic LVL_INACTIVE = 1'b0;

endpackage

// File: rtl/chan_ref_cmp.sv
module chan_ref_cmp #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             is_eq,
    output logic             is_lt,
    output logic             is_gt
);

    always_comb begin
        is_eq = (cnt_val == cmp_val);
        is_lt = (cnt_val <  cmp_val);
        is_gt = (cnt_val >  cmp_val);
    end

endmodule

// File: rtl/chan_ref_clrfsm.sv
module chan_ref_clrfsm
    import chan_ref_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xclr_in,
    input  logic       xclr_en,
    input  logic       upd_evt,
    output clr_state_e state,
    output logic       kill
);

    clr_state_e state_d;
    logic       arm;

    assign arm = xclr_in & xclr_en;

    // next-state and output decode
    always_comb begin
        state_d = state;
        kill    = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (arm) begin
                    state_d = ST_CLEARED;          // ARM
                    kill    = 1'b1;
                end
            end
            ST_CLEARED: begin
                if (arm) begin
                    state_d = ST_CLEARED;          // STAY_CLEARED, clear wins
                    kill    = 1'b1;
                end else if (upd_evt) begin
                    state_d = ST_RUN;              // RELEASE
                    kill    = 1'b0;
                end else begin
                    kill    = 1'b1;                // STAY_CLEARED
                end
            end
            default: begin
                state_d = ST_RUN;
                kill    = 1'b0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_d;
    end

    // R8: a clear in the same cycle as an update keeps the state armed
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (xclr_in && xclr_en) |=> (state == ST_CLEARED));

    // R8: release on an update with no clear
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEARED && upd_evt && !(xclr_in && xclr_en)) |=> (state == ST_RUN));

    // R7: run state is left only through an enabled clear
    a_r7_arm_only_by_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !(xclr_in && xclr_en)) |=> (state == ST_RUN));

endmodule

// File: rtl/chan_ref_lvl.sv
module chan_ref_lvl
    import chan_ref_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       cnt_down,
    input  logic       cnt_tick,
    input  logic       is_eq,
    input  logic       is_lt,
    input  logic       is_gt,
    input  logic       cur_lvl,
    output logic       nxt_lvl
);

    logic hit;
    logic pwm_a;

    assign hit = cnt_tick & is_eq;

    // pulse-width mode A level for the current direction
    always_comb begin
        if (cnt_down) pwm_a = is_gt ? LVL_INACTIVE : LVL_ACTIVE;
        else          pwm_a = is_lt ? LVL_ACTIVE   : LVL_INACTIVE;
    end

    always_comb begin
        unique case (cmp_mode_e'(mode))
            CM_HOLD:     nxt_lvl = cur_lvl;
            CM_SET:      nxt_lvl = hit ? LVL_ACTIVE   : cur_lvl;
            CM_CLR:      nxt_lvl = hit ? LVL_INACTIVE : cur_lvl;
            CM_TOGGLE:   nxt_lvl = hit ? ~cur_lvl     : cur_lvl;
            CM_FORCE_LO: nxt_lvl = LVL_INACTIVE;
            CM_FORCE_HI: nxt_lvl = LVL_ACTIVE;
            CM_PWM_A:    nxt_lvl = pwm_a;
            CM_PWM_B:    nxt_lvl = ~pwm_a;
            default:     nxt_lvl = cur_lvl;
        endcase
    end

endmodule

// File: rtl/chan_ref_gen.sv
module chan_ref_gen
    import chan_ref_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic             cnt_tick,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [2:0]       mode,
    input  logic             xclr_in,
    input  logic             xclr_en,
    input  logic             upd_evt,
    output logic             ref_out
);

    logic       is_eq, is_lt, is_gt;
    logic       nxt_lvl;
    logic       kill;
    clr_state_e clr_state;

    chan_ref_cmp #(.CNT_W(CNT_W)) u_cmp (
        .cnt_val (cnt_val),
        .cmp_val (cmp_val),
        .is_eq   (is_eq),
        .is_lt   (is_lt),
        .is_gt   (is_gt)
    );

    chan_ref_clrfsm u_clr (
        .clk     (clk),
        .rst_n   (rst_n),
        .xclr_in (xclr_in),
        .xclr_en (xclr_en),
        .upd_evt (upd_evt),
        .state   (clr_state),
        .kill    (kill)
    );

    chan_ref_lvl u_lvl (
        .mode     (mode),
        .cnt_down (cnt_down),
        .cnt_tick (cnt_tick),
        .is_eq    (is_eq),
        .is_lt    (is_lt),
        .is_gt    (is_gt),
        .cur_lvl  (ref_out),
        .nxt_lvl  (nxt_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ref_out <= LVL_INACTIVE;
        else if (kill) ref_out <= LVL_INACTIVE;
        else           ref_out <= nxt_lvl;
    end

    // R7: an enabled clear pulls the level low at the next edge
    a_r7_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
        (xclr_in && xclr_en) |=> !ref_out);

    // R8: held low while armed and no update arrives
    a_r8_held_low: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_state == ST_CLEARED && !upd_evt) |=> !ref_out);

    // R1: hold mode keeps the level
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && !(xclr_in && xclr_en) && clr_state == ST_RUN) |=> $stable(ref_out));

    // R3: toggle on a ticked match
    a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && cnt_tick && cnt_val == cmp_val && !(xclr_in && xclr_en)
         && clr_state == ST_RUN) |=> (ref_out != $past(ref_out)));

    // R4: forced high
    a_r4_force_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd5 && !(xclr_in && xclr_en) && clr_state == ST_RUN) |=> ref_out);

    // R5: mode A, up-counting below the compare value is active
    a_r5_pwm_up_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6 && !cnt_down && cnt_val < cmp_val && !(xclr_in && xclr_en)
         && clr_state == ST_RUN) |=> ref_out);

    // R6: mode B, down-counting above the compare value is active
    a_r6_pwm_down_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd7 && cnt_down && cnt_val > cmp_val && !(xclr_in && xclr_en)
         && clr_state == ST_RUN) |=> ref_out);

endmodule

// File: tb/chan_ref_gen_bench.sv
module chan_ref_gen_bench;

    localparam int W     = 8;
    localparam int NVEC  = 24;
    localparam int VBITS = 3 + 1 + 1 + W + W + 1 + 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic         cnt_down = 1'b0;
    logic         cnt_tick = 1'b0;
    logic [W-1:0] cmp_val = '0;
    logic [2:0]   mode = 3'd0;
    logic         xclr_in = 1'b0;
    logic         xclr_en = 1'b0;
    logic         upd_evt = 1'b0;
    logic         ref_out;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    chan_ref_gen #(.CNT_W(W)) u_chan_ref_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_val  (cnt_val),
        .cnt_down (cnt_down),
        .cnt_tick (cnt_tick),
        .cmp_val  (cmp_val),
        .mode     (mode),
        .xclr_in  (xclr_in),
        .xclr_en  (xclr_en),
        .upd_evt  (upd_evt),
        .ref_out  (ref_out)
    );

    // {mode, down, tick, cnt, cmp, expected ref after the edge, requirement}
    localparam logic [VBITS-1:0] VEC [NVEC] = '{
        {3'd5, 1'b0, 1'b0, 8'd0, 8'd0, 1'b1, 4'd4},  // R4 force high
        {3'd0, 1'b0, 1'b1, 8'd5, 8'd5, 1'b1, 4'd1},  // R1 hold on match
        {3'd2, 1'b0, 1'b0, 8'd5, 8'd5, 1'b1, 4'd2},  // R2 match without tick
        {3'd2, 1'b0, 1'b1, 8'd4, 8'd5, 1'b1, 4'd2},  // R2 tick without match
        {3'd2, 1'b0, 1'b1, 8'd5, 8'd5, 1'b0, 4'd2},  // R2 clear on match
        {3'd1, 1'b0, 1'b1, 8'd5, 8'd5, 1'b1, 4'd2},  // R2 set on match
        {3'd4, 1'b0, 1'b1, 8'd5, 8'd5, 1'b0, 4'd4},  // R4 force low
        {3'd3, 1'b0, 1'b1, 8'd9, 8'd9, 1'b1, 4'd3},  // R3 toggle up
        {3'd3, 1'b0, 1'b1, 8'd9, 8'd9, 1'b0, 4'd3},  // R3 toggle down
        {3'd3, 1'b0, 1'b1, 8'd8, 8'd9, 1'b0, 4'd3},  // R3 no match
        {3'd3, 1'b0, 1'b1, 8'd9, 8'd9, 1'b1, 4'd3},  // R3 toggle again
        {3'd6, 1'b0, 1'b1, 8'd3, 8'd7, 1'b1, 4'd5},  // R5 up below
        {3'd6, 1'b0, 1'b1, 8'd7, 8'd7, 1'b0, 4'd5},  // R5 up equal
        {3'd6, 1'b0, 1'b1, 8'd9, 8'd7, 1'b0, 4'd5},  // R5 up above
        {3'd6, 1'b1, 1'b1, 8'd9, 8'd7, 1'b0, 4'd5},  // R5 down above
        {3'd6, 1'b1, 1'b1, 8'd7, 8'd7, 1'b1, 4'd5},  // R5 down equal
        {3'd6, 1'b1, 1'b1, 8'd2, 8'd7, 1'b1, 4'd5},  // R5 down below
        {3'd7, 1'b0, 1'b1, 8'd3, 8'd7, 1'b0, 4'd6},  // R6 up below
        {3'd7, 1'b0, 1'b1, 8'd7, 8'd7, 1'b1, 4'd6},  // R6 up equal
        {3'd7, 1'b1, 1'b1, 8'd7, 8'd7, 1'b0, 4'd6},  // R6 down equal
        {3'd7, 1'b1, 1'b1, 8'd9, 8'd7, 1'b1, 4'd6},  // R6 down above
        {3'd6, 1'b0, 1'b1, 8'd0, 8'd0, 1'b0, 4'd5},  // R5 zero compare
        {3'd6, 1'b0, 1'b1, 8'd0, 8'd255, 1'b1, 4'd5},// R5 full compare
        {3'd5, 1'b1, 1'b0, 8'd1, 8'd2, 1'b1, 4'd4}   // R4 force high again
    };

    task automatic check(input logic exp, input string req, input string what);
        checks++;
        if (ref_out !== exp) begin
            errors++;
            $display("FAIL %s %s: ref_out=%0b expected=%0b", req, what, ref_out, exp);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        // reset state, R9
        #3;
        check(1'b0, "R9", "during reset");
        @(posedge clk); #1;
        rst_n = 1'b1;
        edge_step();
        check(1'b0, "R9", "after reset release");

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [VBITS-1:0] v;
            v        = VEC[i];
            mode     = v[VBITS-1 -: 3];
            cnt_down = v[VBITS-4];
            cnt_tick = v[VBITS-5];
            cnt_val  = v[VBITS-6 -: W];
            cmp_val  = v[VBITS-6-W -: W];
            edge_step();
            check(v[4], $sformatf("R%0d", v[3:0]), $sformatf("vector %0d", i));
        end

        // R9: mode change appears only after the next edge
        mode = 3'd4;
        #1;
        check(1'b1, "R9", "before edge after mode change");
        edge_step();
        check(1'b0, "R9", "after edge after mode change");

        // R7: clear without enable is ignored
        mode = 3'd5;
        edge_step();
        xclr_in = 1'b1; xclr_en = 1'b0;
        edge_step();
        check(1'b1, "R7", "clear disabled");
        // R7: enabled clear
        xclr_en = 1'b1;
        edge_step();
        check(1'b0, "R7", "clear enabled");
        xclr_in = 1'b0;
        edge_step();
        check(1'b0, "R8", "held after clear drop");
        edge_step();
        check(1'b0, "R8", "still held");
        // R8: clear and update together, clear wins
        xclr_in = 1'b1; upd_evt = 1'b1;
        edge_step();
        check(1'b0, "R8", "clear with update");
        xclr_in = 1'b0; upd_evt = 1'b0;
        edge_step();
        check(1'b0, "R8", "held after simultaneous");
        // R8: release
        upd_evt = 1'b1;
        edge_step();
        check(1'b1, "R8", "release edge");
        upd_evt = 1'b0;
        edge_step();
        check(1'b1, "R8", "after release");

        // R8: toggle resumes from 0 on release
        mode = 3'd3; cnt_tick = 1'b0;
        xclr_in = 1'b1;
        edge_step();
        check(1'b0, "R8", "cleared in toggle mode");
        xclr_in = 1'b0; cnt_tick = 1'b1; cnt_val = 8'd4; cmp_val = 8'd4;
        edge_step();
        check(1'b0, "R8", "match ignored while held");
        upd_evt = 1'b1;
        edge_step();
        check(1'b1, "R8", "toggle from 0 at release");
        upd_evt = 1'b0; xclr_en = 1'b0; cnt_tick = 1'b0;

        // R9: asynchronous reset from a high level
        mode = 3'd5;
        edge_step();
        check(1'b1, "R4", "high before reset");
        rst_n = 1'b0;
        #1;
        check(1'b0, "R9", "async reset");
        edge_step();
        rst_n = 1'b1;
        mode = 3'd0;
        edge_step();
        check(1'b0, "R9", "hold after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: ref_out=%0b expected=finish", ref_out);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule